// File: doc/BRIEF.md
# Periodic Core-Routed Interrupt Timer

This block is a memory-mapped periodic interrupt source for a cluster of four cores. Software sets a 28-bit period and turns on the timer. The block then counts that period down on a single-cycle reference tick. On every expiry it reloads itself and sets a sticky pending flag. The flag stays set until software acknowledges it, and it is presented as bit 11 of the interrupt-source vector of one chosen core, on either that core's normal (IRQ) or fast (FIQ) path.

Three 32-bit registers sit on a simple write-strobe and combinational-read port, and each has a byte address: a steering register at 0x24, a control/status register at 0x34 and a write-only acknowledge register at 0x38. The reference tick is an enable input in the block's own clock domain. A tick rate of 38.4 MHz makes one period equal to the programmed value in reference-clock cycles.

Top module: `periodic_core_timer`

## Requirements
- R1: After reset the steering value, the period, both enables and the pending flag are zero, every register reads zero and all interrupt outputs are low.
- R2: A write to 0x24 keeps only data bits 2:0, and a read returns them zero-extended. Bits 1:0 give the target core (0 to 3), and bit 2 set picks the FIQ path instead of IRQ. The steering takes effect on the cycle after the write.
- R3: A read of 0x34 returns the period in bits 27:0, count-enable in bit 28, interrupt-enable in bit 29, zero in bit 30 and the pending flag in bit 31. A write stores bits 29:0. Bits 30 and 31 are ignored on write.
- R4: While the flag is pending, exactly one output bit is high. It is bit 11 of the 12-bit slice (slice c occupies bits 12c+11:12c) of `irq_src` when steering bit 2 is 0, or of `fiq_src` when it is 1, where c is the steered core. All other output bits are zero.
- R5: A write to 0x34 with bits 28 and 29 both set loads the counter with the new period P. With P above zero, the flag is set by the P-th reference tick after that write. The counter then reloads itself and sets the flag again every P ticks after that. Clock cycles without a tick do not advance the count.
- R6: The pending flag stays set until a write to 0x38 with bit 31 set or a write to 0x34 with bit 29 clear. The latter also stops the timer. If an expiry falls in the same cycle as a bit-31 acknowledge, the flag stays set.
- R7: A write to 0x38 with bit 30 set restarts the count from the stored period, so the next expiry comes P ticks later. A tick in the same cycle as the restart does not count.
- R8: Reads of 0x38 return zero. A write to 0x38 with bits 31 and 30 both clear changes nothing.
- R9: With a period of zero the timer never sets the flag, whatever the enables.
- R10: With interrupt-enable set and count-enable clear, the count holds still, and a flag that is already pending stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_src | output | 48 | Per-core IRQ source vectors, 12 bits per core |
| fiq_src | output | 48 | Per-core FIQ source vectors, 12 bits per core |

## Verification
A register write is captured at the rising edge it is presented on. Its readback and its effect on the outputs are due in the same clock period, after that edge. The pending flag and the interrupt outputs change at the rising edge of the tick that completes a period, with no further register stage. The bench therefore drives every input just after a falling edge. It samples the read port and both source vectors at the next falling edge, one full edge after the update. A behavioural model, advanced on each rising edge, predicts the source vectors for that sampling point.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int PERIOD_W = 28;

  localparam logic [ADDR_W-1:0] OFS_STEER = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h38;

  localparam int BIT_CNT_EN  = 28;
  localparam int BIT_INT_EN  = 29;
  localparam int BIT_RESTART = 30;
  localparam int BIT_CLEAR   = 31;
endpackage

// File: rtl/ptimer_regs.sv
`timescale 1ns/1ps
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int STEER_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BIT_INT_EN:0] wdata,
  output logic [STEER_W-1:0]  steer_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic                cnt_en_q,
  output logic                int_en_q
);
  logic [STEER_W-1:0]  steer_d;
  logic [PERIOD_W-1:0] period_d;
  logic                cnt_en_d;
  logic                int_en_d;
  logic                steer_we;
  logic                ctrl_we;

  assign steer_we = wr_en && (addr == OFS_STEER);
  assign ctrl_we  = wr_en && (addr == OFS_CTRL);

  always_comb begin
    steer_d  = steer_q;
    period_d = period_q;
    cnt_en_d = cnt_en_q;
    int_en_d = int_en_q;
    if (steer_we) begin
      steer_d = wdata[STEER_W-1:0];
    end
    if (ctrl_we) begin
      period_d = wdata[PERIOD_W-1:0];
      cnt_en_d = wdata[BIT_CNT_EN];
      int_en_d = wdata[BIT_INT_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_q  <= '0;
      period_q <= '0;
      cnt_en_q <= 1'b0;
      int_en_q <= 1'b0;
    end else begin
      steer_q  <= steer_d;
      period_q <= period_d;
      cnt_en_q <= cnt_en_d;
      int_en_q <= int_en_d;
    end
  end
endmodule

// File: rtl/ptimer_counter.sv
`timescale 1ns/1ps
module ptimer_counter
  import ptimer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic                load,
  input  logic [PERIOD_W-1:0] load_val,
  input  logic                clr_req,
  input  logic                kill,
  output logic                pend_q
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] cnt_d;
  logic                pend_d;
  logic                step;
  logic                expire;

  // A count step happens only on an enabled tick with a non-zero period,
  // and never in a cycle where software reloads the counter.
  assign step   = run && tick && (period != '0) && !load;
  assign expire = step && (cnt_q <= PERIOD_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (expire) begin
      cnt_d = period;
    end else if (step) begin
      cnt_d = cnt_q - PERIOD_W'(1);
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (kill) begin
      pend_d = 1'b0;
    end else if (expire) begin
      pend_d = 1'b1;
    end else if (clr_req) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ptimer_steer.sv
`timescale 1ns/1ps
module ptimer_steer #(
  parameter int NCORES  = 4,
  parameter int SRC_W   = 12,
  parameter int SRC_BIT = 11,
  localparam int CORE_W  = $clog2(NCORES),
  localparam int STEER_W = CORE_W + 1
) (
  input  logic                    pend,
  input  logic [STEER_W-1:0]      steer,
  output logic [NCORES*SRC_W-1:0] irq_vec,
  output logic [NCORES*SRC_W-1:0] fiq_vec
);
  localparam logic [SRC_W-1:0] SRC_MASK = SRC_W'(1) << SRC_BIT;

  logic use_fiq;
  assign use_fiq = steer[CORE_W];

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic hit;
    assign hit = pend && (steer[CORE_W-1:0] == CORE_W'(c));
    assign irq_vec[c*SRC_W +: SRC_W] = (hit && !use_fiq) ? SRC_MASK : '0;
    assign fiq_vec[c*SRC_W +: SRC_W] = (hit &&  use_fiq) ? SRC_MASK : '0;
  end
endmodule

// File: rtl/periodic_core_timer.sv
`timescale 1ns/1ps
module periodic_core_timer
  import ptimer_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int SRC_W   = 12,
  parameter int SRC_BIT = 11,
  localparam int CORE_W  = $clog2(NCORES),
  localparam int STEER_W = CORE_W + 1,
  localparam int OUT_W   = NCORES * SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [OUT_W-1:0]  irq_src,
  output logic [OUT_W-1:0]  fiq_src
);
  logic [STEER_W-1:0]  steer_w;
  logic [PERIOD_W-1:0] period_w;
  logic                cnt_en_w;
  logic                int_en_w;
  logic                pend_w;
  logic                ctrl_we;
  logic                ack_we;
  logic                ctrl_load;
  logic                ack_load;
  logic                cnt_load;
  logic [PERIOD_W-1:0] load_val;
  logic                clr_req;
  logic                kill;

  assign ctrl_we   = bus_wr && (bus_addr == OFS_CTRL);
  assign ack_we    = bus_wr && (bus_addr == OFS_ACK);
  assign ctrl_load = ctrl_we && bus_wdata[BIT_CNT_EN] && bus_wdata[BIT_INT_EN];
  assign ack_load  = ack_we && bus_wdata[BIT_RESTART];
  assign cnt_load  = ctrl_load || ack_load;
  assign load_val  = ctrl_load ? bus_wdata[PERIOD_W-1:0] : period_w;
  assign clr_req   = ack_we && bus_wdata[BIT_CLEAR];
  assign kill      = ctrl_we && !bus_wdata[BIT_INT_EN];

  ptimer_regs #(
    .STEER_W (STEER_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata[BIT_INT_EN:0]),
    .steer_q  (steer_w),
    .period_q (period_w),
    .cnt_en_q (cnt_en_w),
    .int_en_q (int_en_w)
  );

  ptimer_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ref_tick),
    .run      (cnt_en_w && int_en_w),
    .period   (period_w),
    .load     (cnt_load),
    .load_val (load_val),
    .clr_req  (clr_req),
    .kill     (kill),
    .pend_q   (pend_w)
  );

  ptimer_steer #(
    .NCORES  (NCORES),
    .SRC_W   (SRC_W),
    .SRC_BIT (SRC_BIT)
  ) u_steer (
    .pend    (pend_w),
    .steer   (steer_w),
    .irq_vec (irq_src),
    .fiq_vec (fiq_src)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_STEER) begin
      bus_rdata = DATA_W'(steer_w);
    end else if (bus_addr == OFS_CTRL) begin
      bus_rdata = {pend_w, 1'b0, int_en_w, cnt_en_w, period_w};
    end
  end
endmodule

// File: rtl/ptimer_checker.sv
`timescale 1ns/1ps
module ptimer_checker
  import ptimer_pkg::*;
#(
  parameter int OUT_W = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                wbit_clear,
  input logic                wbit_int_en,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [OUT_W-1:0]    irq_src,
  input logic [OUT_W-1:0]    fiq_src,
  input logic                pend,
  input logic [PERIOD_W-1:0] period
);
  logic ack_clear_wr;
  logic int_off_wr;
  assign ack_clear_wr = bus_wr && (bus_addr == OFS_ACK) && wbit_clear;
  assign int_off_wr   = bus_wr && (bus_addr == OFS_CTRL) && !wbit_int_en;

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_ACK) |-> (bus_rdata == '0)); // R8

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_src, fiq_src})); // R4

  AST_OUTPUT_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ($countones({irq_src, fiq_src}) == 1)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack_clear_wr && !int_off_wr) |=> pend); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    int_off_wr |=> !pend); // R6

  AST_ZERO_PERIOD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && (period == '0) && !bus_wr) |=> !pend); // R9

  AST_FLAG_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[BIT_CLEAR] == pend)); // R3
endmodule

bind periodic_core_timer ptimer_checker #(
  .OUT_W (OUT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .wbit_clear  (bus_wdata[31]),
  .wbit_int_en (bus_wdata[29]),
  .bus_rdata   (bus_rdata),
  .irq_src     (irq_src),
  .fiq_src     (fiq_src),
  .pend        (pend_w),
  .period      (period_w)
);

// File: tb/periodic_core_timer_test.sv
`timescale 1ns/1ps
module periodic_core_timer_test;
  logic        clk;
  logic        rst_n;
  logic        ref_tick;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [47:0] irq_src;
  logic [47:0] fiq_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  periodic_core_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .fiq_src   (fiq_src)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model, advanced on each rising edge.
  int m_steer, m_period, m_count;
  bit m_cen, m_ien, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_steer = 0; m_period = 0; m_count = 0;
      m_cen = 0; m_ien = 0; m_pend = 0;
    end else begin
      bit running, ld, fired, ctrl_w, ack_w;
      int old_period;
      running    = m_cen && m_ien;
      old_period = m_period;
      ctrl_w     = bus_wr && bus_addr == 8'h34;
      ack_w      = bus_wr && bus_addr == 8'h38;
      ld         = (ctrl_w && bus_wdata[28] && bus_wdata[29]) || (ack_w && bus_wdata[30]);
      fired      = 0;
      if (!ld && running && ref_tick && old_period != 0) begin
        if (m_count <= 1) begin
          fired = 1;
          m_count = old_period;
        end else begin
          m_count = m_count - 1;
        end
      end
      if (ctrl_w && !bus_wdata[29]) m_pend = 0;
      else if (fired) m_pend = 1;
      else if (ack_w && bus_wdata[31]) m_pend = 0;
      if (bus_wr && bus_addr == 8'h24) m_steer = int'(bus_wdata[2:0]);
      if (ctrl_w) begin
        m_period = int'(bus_wdata[27:0]);
        m_cen    = bus_wdata[28];
        m_ien    = bus_wdata[29];
      end
      if (ld) m_count = m_period;
    end
  end

  function automatic logic [47:0] model_vec(bit want_fiq);
    logic [47:0] v = '0;
    if (m_pend && ((m_steer >> 2) & 1) == int'(want_fiq))
      v[(m_steer & 3) * 12 + 11] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison of both source vectors against the model (R4).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq_src vs model", 64'(irq_src), 64'(model_vec(1'b0)));
      chk("R4 fiq_src vs model", 64'(fiq_src), 64'(model_vec(1'b1)));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wr_with_tick(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ref_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ref_tick = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 ctrl after reset", 8'h34, 32'h0);
    rd("R1 steer after reset", 8'h24, 32'h0);
    chk("R1 outputs after reset", 64'(irq_src | fiq_src), 64'h0);

    // R2 steering keeps bits 2:0: core 1, FIQ path
    wr(8'h24, 32'hFFFF_FFFD);
    rd("R2 steer readback", 8'h24, 32'h5);

    // R3 control readback, bits 31:30 ignored on write
    wr(8'h34, 32'hF000_0005);
    rd("R3 ctrl readback", 8'h34, 32'h3000_0005);

    // R5 first expiry on 5th tick
    ticks(4, 0);
    rd("R5 not pending after 4 ticks", 8'h34, 32'h3000_0005);
    ticks(1, 0);
    rd("R5 pending after 5 ticks", 8'h34, 32'hB000_0005);
    chk("R4 core1 FIQ bit 11", 64'(fiq_src), 64'h0080_0000);
    chk("R4 no IRQ when FIQ steered", 64'(irq_src), 64'h0);

    // R8 ack with neither bit is a no-op and reads zero
    wr(8'h38, 32'h0000_1234);
    rd("R8 ack no-op keeps flag", 8'h34, 32'hB000_0005);
    rd("R8 ack reads zero", 8'h38, 32'h0);

    // R6 sticky across a further expiry, then cleared by bit 31
    ticks(5, 1);
    rd("R6 flag sticky", 8'h34, 32'hB000_0005);
    wr(8'h38, 32'h8000_0000);
    rd("R6 ack clears flag", 8'h34, 32'h3000_0005);

    // R5 periodic reload
    ticks(4, 0);
    rd("R5 periodic not yet", 8'h34, 32'h3000_0005);
    ticks(1, 0);
    rd("R5 periodic refire", 8'h34, 32'hB000_0005);
    wr(8'h38, 32'h8000_0000);

    // R7 restart from period
    ticks(3, 0);
    wr(8'h38, 32'h4000_0000);
    ticks(4, 0);
    rd("R7 restart delays expiry", 8'h34, 32'h3000_0005);
    ticks(1, 0);
    rd("R7 expiry after restart", 8'h34, 32'hB000_0005);
    wr(8'h38, 32'h8000_0000);

    // R7 a tick in the restart cycle does not count
    ticks(2, 0);
    wr_with_tick(8'h38, 32'h4000_0000);
    ticks(4, 0);
    rd("R7 restart tick ignored", 8'h34, 32'h3000_0005);
    ticks(1, 0);
    rd("R7 expiry after restart with tick", 8'h34, 32'hB000_0005);

    // R10 count enable off: flag kept, count frozen
    wr(8'h34, 32'h2000_0005);
    rd("R10 flag kept when count stops", 8'h34, 32'hA000_0005);
    wr(8'h38, 32'h8000_0000);
    ticks(10, 0);
    rd("R10 no expiry while frozen", 8'h34, 32'h2000_0005);

    // R6 interrupt-enable clear stops timer and drops flag
    wr(8'h34, 32'h3000_0002);
    ticks(2, 0);
    rd("R6 pending before disable", 8'h34, 32'hB000_0002);
    wr(8'h34, 32'h1000_0002);
    rd("R6 disable clears flag", 8'h34, 32'h1000_0002);
    chk("R6 outputs low after disable", 64'(irq_src | fiq_src), 64'h0);
    ticks(5, 0);
    rd("R6 stays stopped", 8'h34, 32'h1000_0002);

    // R9 zero period never fires
    wr(8'h34, 32'h3000_0000);
    ticks(10, 0);
    rd("R9 zero period silent", 8'h34, 32'h3000_0000);

    // R6 expiry in the same cycle as a clear keeps the flag
    wr(8'h34, 32'h3000_0001);
    ticks(1, 0);
    wr_with_tick(8'h38, 32'h8000_0000);
    rd("R6 expiry beats clear", 8'h34, 32'hB000_0001);
    wr(8'h38, 32'h8000_0000);
    rd("R6 clear without tick", 8'h34, 32'h3000_0001);

    // R4 IRQ path to core 3, ticks with gaps (R5)
    wr(8'h24, 32'h3);
    wr(8'h34, 32'h3000_0003);
    ticks(2, 2);
    rd("R5 gaps do not count", 8'h34, 32'h3000_0003);
    ticks(1, 2);
    chk("R4 core3 IRQ bit 11", 64'(irq_src), 64'h8000_0000_0000);
    chk("R4 no FIQ when IRQ steered", 64'(fiq_src), 64'h0);

    // R2 re-steer while pending: core 0 FIQ
    wr(8'h24, 32'h4);
    chk("R2 re-steer to core0 FIQ", 64'(fiq_src), 64'h800);
    chk("R2 IRQ dropped on re-steer", 64'(irq_src), 64'h0);

    summary();
  end
endmodule